// File: doc/BRIEF.md
# Nibble Radix Sorter

This block takes a 64-bit word holding sixteen 4-bit keys and returns the same keys in ascending order. Nibble i of a word sits in bits 4i+3 down to 4i. In the result, the smallest key is in nibble 0 and the largest in nibble 15. The block uses no comparators. It runs a binary least-significant-digit radix sort as four stable partitions of the whole word, one for each key bit. Bit 0 of every nibble is used first, then bit 1, bit 2 and bit 3.

Each partition copies the selected key bit of every nibble across all four bits of that nibble, which gives a mask. The bits under the mask and the bits under its complement are each gathered toward the low end of the word, keeping their order. The gathered set-bit group is then shifted above the cleared-bit group by the number of cleared mask bits, and the two groups are merged. A pass in which every nibble has the same key bit leaves the word as it was. This holds in both directions, so a shift of 64 gives zero and does not wrap.

The unit is iterative and does one pass per clock. A word is accepted over a valid/ready handshake, only while the unit is idle. The result is held under a valid/ready handshake until the consumer takes it.

Top module: `nibble_radix_sorter`

## Requirements
- R1: When `out_valid` is high, nibble j of `out_data` (bits 4j+3..4j) is less than or equal to nibble j+1 for every j from 0 to 14, so the smallest key is at bits 3..0.
- R2: `out_data` holds the same multiset of sixteen nibble values as the accepted `in_data` word.
- R3: `in_ready` is high exactly when the unit is idle. A word is accepted only on a rising edge where both `in_valid` and `in_ready` are high. `in_valid` and `in_data` presented while the unit is busy have no effect on the result.
- R4: `out_valid` rises on the fourth rising edge after the accepting edge, one edge for each of the four passes.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays stable. The edge where both are high returns the unit to idle, so `in_ready` is high after that edge.
- R6: After reset, `in_ready` is 1 and `out_valid` is 0.
- R7: A word whose sixteen nibbles are all equal comes out unchanged. Every pass then has a uniform mask (all zeros or all ones) and leaves the word as it was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Unit is idle and takes a word |
| in_data | input | 64 | Sixteen packed 4-bit keys |
| out_valid | output | 1 | Sorted word is available |
| out_ready | input | 1 | Consumer takes the sorted word |
| out_data | output | 64 | Sixteen keys in ascending order, smallest in bits 3..0 |

## Verification
The bench builds the block with its default values: 4-bit elements and sixteen of them. With these values, every one of the sixteen key values can occur, including the all-equal words of 0x0 and 0xF whose masks are uniform in every pass. The default values also give the full four-pass latency and words that hold each key value more than once, so stability within a group affects the result. Random words, already sorted and reverse sorted words, and busy-time noise on the input side cover the handshake rules and the ignored inputs at the four-pass depth.

// File: rtl/nrs_pkg.sv
package nrs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } nrs_state_e;
endpackage

// File: rtl/nrs_key_mask.sv
module nrs_key_mask #(
  parameter int ELEM_W = 4,
  parameter int ELEMS  = 16,
  localparam int WORD_W = ELEM_W * ELEMS,
  localparam int SEL_W  = (ELEM_W > 1) ? $clog2(ELEM_W) : 1
) (
  input  logic [WORD_W-1:0] word,
  input  logic [SEL_W-1:0]  sel,
  output logic [WORD_W-1:0] mask
);
  for (genvar e = 0; e < ELEMS; e++) begin : g_elem
    logic [ELEM_W-1:0] elem;
    assign elem = word[e*ELEM_W +: ELEM_W];
    assign mask[e*ELEM_W +: ELEM_W] = {ELEM_W{elem[sel]}};
  end
endmodule

// File: rtl/nrs_compress.sv
module nrs_compress #(
  parameter int W = 64,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0] data,
  input  logic [W-1:0] sel,
  output logic [W-1:0] packed_o
);
  logic [AW-1:0] pos;
  always_comb begin
    packed_o = '0;
    pos      = '0;
    for (int i = 0; i < W; i++) begin
      if (sel[i]) begin
        packed_o[pos] = data[i];
        pos           = pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nrs_pass.sv
module nrs_pass #(
  parameter int ELEM_W = 4,
  parameter int ELEMS  = 16,
  localparam int WORD_W = ELEM_W * ELEMS,
  localparam int SEL_W  = (ELEM_W > 1) ? $clog2(ELEM_W) : 1,
  localparam int CNT_W  = $clog2(WORD_W) + 1
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [SEL_W-1:0]  bit_sel,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] key_mask, low_grp, high_grp;
  logic [CNT_W-1:0]  zero_cnt;

  nrs_key_mask #(.ELEM_W(ELEM_W), .ELEMS(ELEMS)) mask_i (
    .word(word_i), .sel(bit_sel), .mask(key_mask)
  );

  nrs_compress #(.W(WORD_W)) hi_i (
    .data(word_i), .sel(key_mask), .packed_o(high_grp)
  );

  nrs_compress #(.W(WORD_W)) lo_i (
    .data(word_i), .sel(~key_mask), .packed_o(low_grp)
  );

  always_comb begin
    zero_cnt = '0;
    for (int i = 0; i < WORD_W; i++) begin
      zero_cnt = zero_cnt + {{(CNT_W-1){1'b0}}, ~key_mask[i]};
    end
  end

  // a shift of WORD_W clears the high group instead of wrapping
  assign word_o = (high_grp << zero_cnt) | low_grp;
endmodule

// File: rtl/nibble_radix_sorter.sv
module nibble_radix_sorter #(
  parameter int ELEM_W = 4,
  parameter int ELEMS  = 16,
  localparam int WORD_W = ELEM_W * ELEMS,
  localparam int SEL_W  = (ELEM_W > 1) ? $clog2(ELEM_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  import nrs_pkg::*;

  localparam logic [SEL_W-1:0] LAST_PASS = SEL_W'(ELEM_W - 1);

  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  nrs_state_e        state_q, state_d;
  logic [SEL_W-1:0]  pass_q, pass_d;
  logic [WORD_W-1:0] word_q, word_d, pass_out;
  logic              word_en, pass_en;

  nrs_pass #(.ELEM_W(ELEM_W), .ELEMS(ELEMS)) pass_i (
    .word_i(word_q), .bit_sel(pass_q), .word_o(pass_out)
  );

  always_comb begin
    state_d = state_q;
    pass_d  = pass_q;
    word_d  = word_q;
    word_en = 1'b0;
    pass_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          word_d  = in_data;
          word_en = 1'b1;
          pass_d  = '0;
          pass_en = 1'b1;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        word_d  = pass_out;
        word_en = 1'b1;
        pass_d  = pass_q + 1'b1;
        pass_en = 1'b1;
        if (pass_q == LAST_PASS) state_d = ST_DONE;
      end
      ST_DONE: begin
        if (out_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      pass_q  <= '0;
      word_q  <= '0;
    end else begin
      state_q <= state_d;
      if (pass_en) pass_q <= pass_d;
      if (word_en) word_q <= word_d;
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_DONE);
  assign out_data  = word_q;
endmodule

// File: rtl/nrs_checker.sv
module nrs_checker #(
  parameter int ELEM_W = 4,
  parameter int ELEMS  = 16,
  localparam int WORD_W = ELEM_W * ELEMS,
  localparam int NVAL   = 1 << ELEM_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [WORD_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data
);
  logic [WORD_W-1:0] cap_q;
  logic [7:0]        lat_q;

  function automatic logic ascending(input logic [WORD_W-1:0] w);
    logic ok;
    ok = 1'b1;
    for (int e = 1; e < ELEMS; e++)
      if (w[e*ELEM_W +: ELEM_W] < w[(e-1)*ELEM_W +: ELEM_W]) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic same_keys(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b);
    int ha [NVAL];
    int hb [NVAL];
    logic ok;
    for (int v = 0; v < NVAL; v++) begin ha[v] = 0; hb[v] = 0; end
    for (int e = 0; e < ELEMS; e++) begin
      ha[int'(a[e*ELEM_W +: ELEM_W])]++;
      hb[int'(b[e*ELEM_W +: ELEM_W])]++;
    end
    ok = 1'b1;
    for (int v = 0; v < NVAL; v++) if (ha[v] != hb[v]) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic uniform(input logic [WORD_W-1:0] w);
    logic ok;
    ok = 1'b1;
    for (int e = 1; e < ELEMS; e++)
      if (w[e*ELEM_W +: ELEM_W] != w[ELEM_W-1:0]) ok = 1'b0;
    return ok;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      lat_q <= '0;
    end else if (in_valid && in_ready) begin
      cap_q <= in_data;
      lat_q <= '0;
    end else if (!in_ready && !out_valid) begin
      lat_q <= lat_q + 8'd1;
    end
  end

  AST_OUT_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ascending(out_data)); // R1
  AST_OUT_PERMUTED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> same_keys(cap_q, out_data)); // R2
  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R3
  AST_PASS_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_q == 8'(ELEM_W))); // R4
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R5
  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> in_ready); // R5
  AST_UNIFORM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && uniform(cap_q)) |-> (out_data == cap_q)); // R7
endmodule

bind nibble_radix_sorter nrs_checker #(.ELEM_W(ELEM_W), .ELEMS(ELEMS)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data)
);

// File: tb/nibble_radix_sorter_tb_top.sv
module nibble_radix_sorter_tb_top;
  localparam int EW = 4;
  localparam int NE = 16;
  localparam int WW = EW * NE;

  logic          clk, rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [WW-1:0] in_data, out_data;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  nibble_radix_sorter #(.ELEM_W(EW), .ELEMS(NE)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural model: phase 0 idle, 1..4 passes pending, 5 result held
  int            phase = 0;
  logic [WW-1:0] exp_word = '0;
  logic [WW-1:0] src_word = '0;
  bit            first_out = 0;

  function automatic logic [WW-1:0] count_sort(input logic [WW-1:0] w);
    int hist [16];
    int k;
    logic [WW-1:0] r;
    for (int v = 0; v < 16; v++) hist[v] = 0;
    for (int e = 0; e < NE; e++) hist[int'(w[e*EW +: EW])]++;
    r = '0;
    k = 0;
    for (int v = 0; v < 16; v++)
      for (int c = 0; c < hist[v]; c++) begin
        r[k*EW +: EW] = 4'(v);
        k++;
      end
    return r;
  endfunction

  function automatic bit same_multiset(input logic [WW-1:0] a, input logic [WW-1:0] b);
    int d [16];
    for (int v = 0; v < 16; v++) d[v] = 0;
    for (int e = 0; e < NE; e++) begin
      d[int'(a[e*EW +: EW])]++;
      d[int'(b[e*EW +: EW])]--;
    end
    for (int v = 0; v < 16; v++) if (d[v] != 0) return 0;
    return 1;
  endfunction

  task automatic check(input bit ok, input string req, input logic [WW-1:0] act,
                       input logic [WW-1:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      phase = 0;
    end else begin
      case (phase)
        0: if (in_valid) begin
             src_word  = in_data;
             exp_word  = count_sort(in_data);
             phase     = 1;
             first_out = 1;
           end
        5: if (out_ready) phase = 0;
        default: phase = phase + 1;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(in_ready == (phase == 0), "R3 in_ready", WW'(in_ready), WW'(phase == 0));
      check(out_valid == (phase == 5), "R4 out_valid", WW'(out_valid), WW'(phase == 5));
      if (phase == 5) begin
        check(out_data == exp_word, "R1 sorted data", out_data, exp_word);
        if (!first_out) check(out_data == exp_word, "R5 held data", out_data, exp_word);
        if (first_out) begin
          check(same_multiset(out_data, src_word), "R2 same keys", out_data, src_word);
          first_out = 0;
        end
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // send one word, push noise while busy, stall the consumer for `stall` cycles
  task automatic run_word(input logic [WW-1:0] w, input int stall, input bit noise,
                          input bit uniform_chk);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    @(negedge clk);
    in_valid = noise;
    in_data  = ~w;
    while (!out_valid) @(negedge clk);
    in_valid = 1'b0;
    if (uniform_chk) check(out_data == w, "R7 uniform unchanged", out_data, w);
    repeat (stall) @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(in_ready == 1'b1, "R5 idle after take", WW'(in_ready), WW'(1));
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R6 reset in_ready", WW'(in_ready), WW'(1));
    check(out_valid == 1'b0, "R6 reset out_valid", WW'(out_valid), WW'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R6 after release",
          WW'({in_ready, out_valid}), WW'(2));
    for (int v = 0; v < 16; v++) run_word({16{4'(v)}}, v % 3, 1'b1, 1'b1);
    run_word(64'h0123456789ABCDEF, 0, 1'b0, 1'b0);
    run_word(64'hFEDCBA9876543210, 2, 1'b1, 1'b0);
    run_word(64'hF0F0F0F0F0F0F0F0, 1, 1'b0, 1'b0);
    run_word(64'h0000000000000001, 0, 1'b1, 1'b0);
    run_word(64'h8000000000000000, 0, 1'b0, 1'b0);
    for (int n = 0; n < 300; n++)
      run_word({$urandom, $urandom}, n % 4, n[0], 1'b0);
    finished = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      mismatched++;
      compared++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end
endmodule